// File: doc/BRIEF.md
# Six-Channel Pulse-Width Modulator with Filtered Fault Shutdown

This block drives six pulse-width-modulated outputs from one shared timebase. The timebase can run in one of two ways. In edge-aligned mode it climbs and wraps. In center-aligned mode it rises to the programmed period and falls back, so pulses are symmetric about the period boundary. Each channel compares a phase-shifted copy of the timebase against its own duty value. Software can therefore stagger the channels in time without running separate counters.

Four fault pins protect the load. Each pin passes through a run-length filter, so short glitches are ignored. When an enabled pin stays asserted for the programmed number of clocks, all six outputs are gated low in that same cycle. A sticky status bit then records the event. The outputs stay low until software clears the bit by writing a one to it.

All settings are held in a small word-addressed register file. New duty and phase values are staged in shadow registers. They are copied into the compare path only when the timebase wraps to the start of a period.

Top module: `pwm6_fault`

## Requirements
- R1: In edge-aligned mode (control bit 0 = 0) with period P > 0, the timebase visits positions 0, 1, ..., P-1 and then wraps, so every output pattern repeats every P clocks.
- R2: In center-aligned mode (control bit 0 = 1), the timebase rises from 0 to P and falls back toward 0, giving a pattern that repeats every 2P clocks.
- R3: A channel's output is high while its phase-adjusted compare value is below its active duty value. A duty of 0 gives a constant low output. A nonzero duty at or above P gives a constant high output.
- R4: The phase-adjusted position is (position + phase) modulo the pattern length (P or 2P). In center-aligned mode, an adjusted position a greater than P is folded to 2P - a before the compare. Phase values must lie below the pattern length.
- R5: Writes to duty (addresses 8 to 13) and phase (addresses 16 to 21) land in shadow registers. The compare path picks them up only on the clock edge where the timebase wraps to position 0. While the period is 0, that happens on every edge.
- R6: Fault pin j qualifies after it is sampled high on N consecutive rising edges, where N is control bits [11:8]. A value of 0 is treated as 1. Any low sample restarts the count.
- R7: A qualified fault whose enable (control bit 4+j) is set drives all six outputs low starting right after the qualifying edge. The outputs stay low for as long as that pin's status bit and enable are both set.
- R8: Status register (address 2) bit j is set one edge after pin j is qualified while enabled. Writing a one to a bit clears it, and zeros leave bits unchanged. A disabled pin neither sets status nor touches the outputs.
- R9: After reset every register reads 0 and all outputs are low. Address 0 holds the period in bits [14:0], address 1 holds the control word, and duty and phase registers read back their shadow values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| fault_in | input | 4 | Fault pins, synchronous to clk, active high |
| pwm_out | output | 6 | Modulated outputs |

## Verification
The bench builds the block with its default parameters: 15-bit counters, six channels, four fault pins and a 4-bit filter length. Because the period is a register, the bench can program periods of 1 to 6. That makes it possible to sweep every duty from 0 to P+1 against every legal phase, in both counting modes, and to compare each cycle against an arithmetic model. The default filter width lets the bench reach the zero-means-one length, runs that stop one short of the threshold, and exact qualification.

// File: rtl/pwm6_fault.sv
module pwm6_fault #(
  parameter int CW   = 15,
  parameter int NCH  = 6,
  parameter int NFLT = 4,
  parameter int FLW  = 4,
  parameter int AW   = 5,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [NFLT-1:0] fault_in,
  output logic [NCH-1:0]  pwm_out
);
  localparam int PW      = CW + 1;
  localparam int A_PER   = 0;
  localparam int A_CTRL  = 1;
  localparam int A_STAT  = 2;
  localparam int A_DUTY  = 8;
  localparam int A_PHASE = 16;
  localparam int EN_LSB  = 4;
  localparam int FL_LSB  = EN_LSB + NFLT;

  logic [CW-1:0]             period_q;
  logic                      center_q;
  logic [NFLT-1:0]           fen_q;
  logic [FLW-1:0]            flen_q;
  logic [NFLT-1:0]           fstat_q;
  logic [NCH-1:0][CW-1:0]    duty_sh, duty_act, ph_sh, ph_act;
  logic [PW-1:0]             pos_q;
  logic [NCH-1:0]            pwm_q, raw;
  logic [NFLT-1:0][FLW-1:0]  fcnt;
  logic [NFLT-1:0]           fqual;

  // timebase
  logic [PW-1:0] len;
  logic          wrap;
  logic [FLW-1:0] nsel;
  logic          kill;

  assign len  = center_q ? {period_q, 1'b0} : {1'b0, period_q};
  assign wrap = ((PW+1)'(pos_q) + (PW+1)'(1)) >= (PW+1)'(len);
  assign nsel = (flen_q == '0) ? FLW'(1) : flen_q;
  assign kill = |((fqual | fstat_q) & fen_q);
  assign pwm_out = kill ? '0 : pwm_q;

  // per-channel compare
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [PW:0]   sum, adjw;
    logic [PW-1:0] adj, v;
    assign sum  = (PW+1)'(pos_q) + (PW+1)'(ph_act[i]);
    assign adjw = (sum >= (PW+1)'(len)) ? sum - (PW+1)'(len) : sum;
    assign adj  = adjw[PW-1:0];
    assign v    = (center_q && adj > PW'(period_q)) ? len - adj : adj;
    assign raw[i] = (duty_act[i] != '0) &&
                    ((duty_act[i] >= period_q) || (v < PW'(duty_act[i])));

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(duty_act[i]) == '0) |-> !pwm_out[i]); // R3
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= '0;
      duty_act <= '0;
      ph_act   <= '0;
      pwm_q    <= '0;
    end else begin
      pwm_q <= raw;
      if (wrap) begin
        pos_q    <= '0;
        duty_act <= duty_sh;
        ph_act   <= ph_sh;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  // fault filters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt  <= '0;
      fqual <= '0;
    end else begin
      for (int j = 0; j < NFLT; j++) begin
        if (!fault_in[j]) begin
          fcnt[j]  <= '0;
          fqual[j] <= 1'b0;
        end else begin
          if (fcnt[j] < nsel) fcnt[j] <= fcnt[j] + 1'b1;
          fqual[j] <= ((FLW+1)'(fcnt[j]) + (FLW+1)'(1)) >= (FLW+1)'(nsel);
        end
      end
    end
  end

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      center_q <= 1'b0;
      fen_q    <= '0;
      flen_q   <= '0;
      fstat_q  <= '0;
      duty_sh  <= '0;
      ph_sh    <= '0;
    end else begin
      fstat_q <= (fstat_q & ~((wr_en && wr_addr == AW'(A_STAT)) ? wr_data[NFLT-1:0] : '0))
                 | (fqual & fen_q);
      if (wr_en) begin
        if (wr_addr == AW'(A_PER)) period_q <= wr_data[CW-1:0];
        if (wr_addr == AW'(A_CTRL)) begin
          center_q <= wr_data[0];
          fen_q    <= wr_data[EN_LSB +: NFLT];
          flen_q   <= wr_data[FL_LSB +: FLW];
        end
        for (int i = 0; i < NCH; i++) begin
          if (wr_addr == AW'(A_DUTY + i))  duty_sh[i] <= wr_data[CW-1:0];
          if (wr_addr == AW'(A_PHASE + i)) ph_sh[i]   <= wr_data[CW-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(A_PER)) rd_data[CW-1:0] = period_q;
    if (rd_addr == AW'(A_CTRL)) begin
      rd_data[0]                = center_q;
      rd_data[EN_LSB +: NFLT]   = fen_q;
      rd_data[FL_LSB +: FLW]    = flen_q;
    end
    if (rd_addr == AW'(A_STAT)) rd_data[NFLT-1:0] = fstat_q;
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == AW'(A_DUTY + i))  rd_data[CW-1:0] = duty_sh[i];
      if (rd_addr == AW'(A_PHASE + i)) rd_data[CW-1:0] = ph_sh[i];
    end
  end

  // checks
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (len != '0 && pos_q >= len) |=> (pos_q == '0)); // R1

  AST_ACT_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap) |-> ($stable(duty_act) && $stable(ph_act))); // R5

  AST_OUT_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fstat_q & fen_q)) |-> (pwm_out == '0)); // R7

  for (genvar j = 0; j < NFLT; j++) begin : g_fchk
    AST_QUAL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fqual[j]) |-> $past(fault_in[j])); // R6
    AST_STICKY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fstat_q[j]) |-> $past(fqual[j] & fen_q[j])); // R8
  end
endmodule

// File: tb/tb_pwm6_fault.sv
module tb_pwm6_fault;
  localparam int NCH = 6, NFLT = 4, AW = 5, DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0, rd_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic [NFLT-1:0] fault_in = '0;
  wire  [DW-1:0]   rd_data;
  wire  [NCH-1:0]  pwm_out;

  pwm6_fault dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fault_in(fault_in), .pwm_out(pwm_out)
  );

  int vectors = 0, errors = 0;
  bit chk = 1'b0;
  string tag = "R9";

  // arithmetic reference of the requirements
  int m_pos, m_P, m_mode;
  int m_dsh[NCH], m_dact[NCH], m_psh[NCH], m_pact[NCH];
  logic [NCH-1:0] exp_q = '0;

  function automatic bit ref_out(int pos, int P, int mode, int d, int ph);
    int L = mode ? 2 * P : P;
    int s = pos + ph;
    int a = (s >= L) ? s - L : s;
    int v = (mode != 0 && a > P) ? L - a : a;
    return (d != 0) && (d >= P || v < d);
  endfunction

  always @(posedge clk) begin
    int L;
    if (!rst_n) begin
      m_pos = 0; m_P = 0; m_mode = 0; exp_q = '0;
      for (int c = 0; c < NCH; c++) begin
        m_dsh[c] = 0; m_dact[c] = 0; m_psh[c] = 0; m_pact[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) exp_q[c] = ref_out(m_pos, m_P, m_mode, m_dact[c], m_pact[c]);
      L = m_mode ? 2 * m_P : m_P;
      if (m_pos + 1 >= L) begin
        m_pos = 0;
        for (int c = 0; c < NCH; c++) begin m_dact[c] = m_dsh[c]; m_pact[c] = m_psh[c]; end
      end else m_pos = m_pos + 1;
      if (wr_en) begin
        if (wr_addr == 0) m_P = int'(wr_data[14:0]);
        if (wr_addr == 1) m_mode = int'(wr_data[0]);
        for (int c = 0; c < NCH; c++) begin
          if (int'(wr_addr) == 8 + c)  m_dsh[c] = int'(wr_data[14:0]);
          if (int'(wr_addr) == 16 + c) m_psh[c] = int'(wr_data[14:0]);
        end
      end
    end
  end

  always @(negedge clk) if (chk) begin
    vectors++;
    if (pwm_out !== exp_q) begin
      errors++;
      $display("FAIL %s: pwm_out=%b expected %b", tag, pwm_out, exp_q);
    end
  end

  task automatic check(string t, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string t, int a, int exp);
    rd_addr = AW'(a); #1;
    check(t, rd_data, DW'(exp));
  endtask

  task automatic do_reset();
    chk = 1'b0; #2;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
  endtask

  task automatic run_set(int mode, int P, int d[NCH], int ph[NCH]);
    do_reset();
    chk = 1'b1;
    for (int c = 0; c < NCH; c++) begin wr(8 + c, d[c]); wr(16 + c, ph[c]); end
    wr(1, mode);
    wr(0, P);
    repeat (2 * (mode ? 2 * P : P) + 3) @(negedge clk);
  endtask

  initial begin
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int d[NCH], ph[NCH], n;
    // R9 reset state
    do_reset();
    check("R9 outputs after reset", DW'(pwm_out), '0);
    rd_check("R9 period", 0, 0);
    rd_check("R9 control", 1, 0);
    rd_check("R9 status", 2, 0);
    rd_check("R9 duty0", 8, 0);
    rd_check("R9 phase5", 21, 0);
    wr(0, 1234); rd_check("R9 period readback", 0, 1234);
    wr(1, 16'h0A51); rd_check("R9 control readback", 1, 16'h0A51);
    wr(13, 777);  rd_check("R9 duty5 readback", 13, 777);
    wr(18, 42);   rd_check("R9 phase2 readback", 18, 42);

    // R1 R2 R3 R4 sweep over every duty and phase for small periods
    for (int mode = 0; mode < 2; mode++) begin
      tag = mode ? "R2/R3/R4 center" : "R1/R3/R4 edge";
      for (int P = 1; P <= 6; P++) begin
        n = 0;
        for (int dv = 0; dv <= P + 1; dv++)
          for (int pv = 0; pv < (mode ? 2 * P : P); pv++) begin
            d[n] = dv; ph[n] = pv; n++;
            if (n == NCH) begin run_set(mode, P, d, ph); n = 0; end
          end
        if (n != 0) begin
          for (int c = n; c < NCH; c++) begin d[c] = 0; ph[c] = 0; end
          run_set(mode, P, d, ph);
        end
      end
    end

    // R5 mid-period updates wait for the wrap
    tag = "R5 edge";
    for (int c = 0; c < NCH; c++) begin d[c] = c; ph[c] = c % 5; end
    run_set(0, 5, d, ph);
    repeat (2) @(negedge clk);
    wr(8, 4); wr(16, 3); wr(9, 0);
    repeat (13) @(negedge clk);
    tag = "R5 center";
    run_set(1, 4, d, ph);
    repeat (3) @(negedge clk);
    wr(10, 1); wr(18, 6);
    repeat (20) @(negedge clk);

    // R6 R7 R8 faults with all outputs held high
    do_reset();
    for (int c = 0; c < NCH; c++) wr(8 + c, 4);
    wr(1, (3 << 8) | (1 << 4));
    wr(0, 4);
    repeat (2) @(negedge clk);
    check("R3 duty at period is high", DW'(pwm_out), DW'(6'h3F));
    fault_in[0] = 1'b1; repeat (2) @(negedge clk);
    check("R6 two of three samples", DW'(pwm_out), DW'(6'h3F));
    fault_in[0] = 1'b0; @(negedge clk);
    check("R6 run broken", DW'(pwm_out), DW'(6'h3F));
    rd_check("R6 no status on short run", 2, 0);
    fault_in[0] = 1'b1; repeat (3) @(negedge clk);
    check("R7 outputs low on qualifying edge", DW'(pwm_out), '0);
    fault_in[0] = 1'b0; repeat (3) @(negedge clk);
    check("R7 outputs held while status set", DW'(pwm_out), '0);
    rd_check("R8 status latched", 2, 1);
    wr(2, 1);
    rd_check("R8 status cleared", 2, 0);
    check("R8 outputs resume after clear", DW'(pwm_out), DW'(6'h3F));
    fault_in[1] = 1'b1; repeat (6) @(negedge clk);
    check("R8 disabled pin no effect", DW'(pwm_out), DW'(6'h3F));
    rd_check("R8 disabled pin no status", 2, 0);
    fault_in[1] = 1'b0;
    wr(1, (0 << 8) | (4'b0100 << 4));
    fault_in[2] = 1'b1; @(negedge clk);
    check("R6 length zero acts as one", DW'(pwm_out), '0);
    fault_in[2] = 1'b0; @(negedge clk);
    rd_check("R8 status bit 2", 2, 4);
    wr(2, 4);
    check("R8 cleared bit 2 outputs", DW'(pwm_out), DW'(6'h3F));
    wr(1, (1 << 8) | (4'b1100 << 4));
    fault_in[3:2] = 2'b11; @(negedge clk);
    fault_in[3:2] = 2'b00; @(negedge clk);
    rd_check("R8 two bits latched", 2, 12);
    wr(2, 4);
    rd_check("R8 clear only written ones", 2, 8);
    check("R7 remaining bit keeps outputs low", DW'(pwm_out), '0);
    wr(2, 8);
    check("R8 all clear outputs high", DW'(pwm_out), DW'(6'h3F));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule